// File: doc/BRIEF.md
# Write-Engine Status Byte with Erase Suspend Handshake

This block keeps the status byte that software polls to follow an internal program/erase engine. It tracks whether an operation is running, whether an erase has been parked by a suspend request, and whether the last erase or program failed. Failures are sticky. Once a fail bit is set, new operations cannot start until software issues a clear-status command.

The command decoder sends single-cycle pulses for start, clear-status, suspend, resume and abort. The engine sends a completion pulse (with a fail qualifier) and an acknowledge once it has actually stopped. Suspension is a two-step handshake. Bit 6 and the suspend request to the engine rise first. Bit 7 (ready) returns only when the engine confirms it is parked.

A read access is signalled by a one-cycle pulse on the read-start input. The status value is frozen into an output register on that pulse. It stays unchanged until the next read-start, so polling software must open a new access to see progress. All pins are plain control and status signals. There is no data stream and no back-pressure.

Top module: `pgm_status_ctrl`

## Requirements
- R1: After reset, status bits 7..4 read 1000b, no suspend request is driven, and the start inhibit is low.
- R2: The status byte has this layout: bit 7 ready (1) / busy (0), bit 6 erase suspended, bit 5 erase failed, bit 4 program failed, bit 3 equal to the sector-protect input at capture time. Bits 2..0 always read 0.
- R3: A start request accepted while idle clears bit 7. An engine completion pulse during a running operation sets bit 7 again.
- R4: A completion pulse with the fail qualifier sets bit 5 for an erase or bit 4 for a program. That bit stays set through later completions and starts, and only clear-status removes it.
- R5: Clear-status resets bits 5 and 4 and never changes bit 3. If a fail is set in the same cycle as a clear, the fail bit ends up set.
- R6: The start inhibit output is high while bit 5 or bit 4 is set, or while an operation or a suspension is active. A start request under inhibit is ignored and bit 7 stays 1.
- R7: A suspend command is honoured only while an erase is running. It sets bit 6 and the suspend request output, and bit 7 stays 0. A suspend during a program has no effect.
- R8: Bit 7 rises during a pending suspend only when the engine acknowledges that it is suspended.
- R9: Resume while bit 6 is set clears bit 6 and the suspend request and returns bit 7 to 0. Resume with bit 6 clear has no effect.
- R10: Abort while suspended ends the operation: bit 6 becomes 0 and bit 7 becomes 1. Abort at any other time has no effect.
- R11: The read output takes the live status value on the clock edge where read-start is high. It holds that value, whatever else changes, until the next read-start.
- R12: The 16-bit read output always carries 00h in its upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req_i | input | 1 | Decoder pulse: begin program or erase |
| start_erase_i | input | 1 | Qualifier with start: 1 = erase, 0 = program |
| cmd_clear_i | input | 1 | Clear-status command pulse |
| cmd_suspend_i | input | 1 | Erase-suspend command pulse |
| cmd_resume_i | input | 1 | Erase-resume command pulse |
| cmd_abort_i | input | 1 | Abort command pulse |
| eng_done_i | input | 1 | Engine pulse: operation finished |
| eng_fail_i | input | 1 | Qualifier with done: operation failed |
| eng_susp_ack_i | input | 1 | Engine pulse: erase now parked |
| prot_any_i | input | 1 | High when any protectable sector is protected |
| rd_start_i | input | 1 | Read access begins; capture status |
| susp_req_o | output | 1 | Request to the engine to park the erase |
| start_inhibit_o | output | 1 | New starts are blocked |
| rd_data_o | output | 16 | Captured status (upper byte 00h) |

## Verification
The hardest state to reach from the ports is a suspended erase in each phase. One phase is the pending window, where bit 6 is already 1 and bit 7 is still 0. The other is the parked state after the acknowledge, where only resume or abort act. The stimulus reaches both by starting an erase and issuing a suspend. It then reads status before and after a separate acknowledge pulse. From the parked state it leaves once through resume and once through abort. A suspend sent during a program and a resume sent with nothing suspended confirm that both commands are ignored outside their window.

// File: rtl/pes_pkg.sv
package pes_pkg;
  localparam int STAT_W  = 8;
  localparam int BIT_RDY = 7;
  localparam int BIT_SUS = 6;
  localparam int BIT_EF  = 5;
  localparam int BIT_PF  = 4;
  localparam int BIT_PRT = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SPEND = 2'd2,
    ST_SUSP  = 2'd3
  } eng_st_e;
endpackage

// File: rtl/pes_op_tracker.sv
module pes_op_tracker
  import pes_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req_i,
  input  logic start_erase_i,
  input  logic fail_any_i,
  input  logic cmd_suspend_i,
  input  logic cmd_resume_i,
  input  logic cmd_abort_i,
  input  logic eng_done_i,
  input  logic eng_fail_i,
  input  logic eng_susp_ack_i,
  output logic ready_o,
  output logic susp_o,
  output logic susp_req_o,
  output logic active_o,
  output logic set_efail_o,
  output logic set_pfail_o
);
  eng_st_e st_q, st_d;
  logic    erase_q;
  logic    done_in_op;

  assign done_in_op  = eng_done_i && (st_q == ST_RUN || st_q == ST_SPEND);
  assign set_efail_o = done_in_op && eng_fail_i && erase_q;
  assign set_pfail_o = done_in_op && eng_fail_i && !erase_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_req_i && !fail_any_i) st_d = ST_RUN;
      ST_RUN: begin
        if (eng_done_i)                    st_d = ST_IDLE;
        else if (cmd_suspend_i && erase_q) st_d = ST_SPEND;
      end
      ST_SPEND: begin
        if (eng_done_i)          st_d = ST_IDLE;
        else if (cmd_resume_i)   st_d = ST_RUN;
        else if (eng_susp_ack_i) st_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (cmd_resume_i)     st_d = ST_RUN;
        else if (cmd_abort_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      erase_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_req_i && !fail_any_i) erase_q <= start_erase_i;
    end
  end

  assign ready_o    = (st_q == ST_IDLE) || (st_q == ST_SUSP);
  assign susp_o     = (st_q == ST_SPEND) || (st_q == ST_SUSP);
  assign susp_req_o = susp_o;
  assign active_o   = (st_q != ST_IDLE);

  // R6: a blocked start leaves the block ready
  p_no_start_on_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && fail_any_i) |=> ready_o);
  // R7: suspension only ever enters from a running erase
  p_susp_from_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !erase_q) |=> !susp_o);
  // R8: pending suspend turns ready only on acknowledge
  p_ready_needs_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SPEND && !eng_susp_ack_i && !eng_done_i) |=> !ready_o);
  // R10: abort outside suspension does nothing
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cmd_abort_i && !eng_done_i && !cmd_suspend_i) |=> active_o);
endmodule

// File: rtl/pes_fail_bits.sv
module pes_fail_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic set_efail_i,
  input  logic set_pfail_i,
  input  logic clear_i,
  output logic efail_o,
  output logic pfail_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      efail_o <= 1'b0;
      pfail_o <= 1'b0;
    end else begin
      if (set_efail_i)  efail_o <= 1'b1;
      else if (clear_i) efail_o <= 1'b0;
      if (set_pfail_i)  pfail_o <= 1'b1;
      else if (clear_i) pfail_o <= 1'b0;
    end
  end

  // R4: fail bits are sticky without a clear
  p_efail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (efail_o && !clear_i) |=> efail_o);
  p_pfail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pfail_o && !clear_i) |=> pfail_o);
  // R5: a same-cycle set beats a clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_efail_i && clear_i) |=> efail_o);
endmodule

// File: rtl/pes_snap.sv
module pes_snap #(
  parameter int STAT_W = 8,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [STAT_W-1:0] live_i,
  input  logic [STAT_W-1:0] rst_val_i,
  output logic [OUT_W-1:0]  data_o
);
  localparam int PAD_W = OUT_W - STAT_W;
  logic [STAT_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     snap_q <= rst_val_i;
    else if (cap_i) snap_q <= live_i;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign data_o = {{PAD_W{1'b0}}, snap_q};
    end else begin : g_nopad
      assign data_o = snap_q[OUT_W-1:0];
    end
  endgenerate

  // R11: captured value is frozen between accesses
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(snap_q));
endmodule

// File: rtl/pgm_status_ctrl.sv
module pgm_status_ctrl
  import pes_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req_i,
  input  logic             start_erase_i,
  input  logic             cmd_clear_i,
  input  logic             cmd_suspend_i,
  input  logic             cmd_resume_i,
  input  logic             cmd_abort_i,
  input  logic             eng_done_i,
  input  logic             eng_fail_i,
  input  logic             eng_susp_ack_i,
  input  logic             prot_any_i,
  input  logic             rd_start_i,
  output logic             susp_req_o,
  output logic             start_inhibit_o,
  output logic [OUT_W-1:0] rd_data_o
);
  logic ready, susp, active, set_ef, set_pf, efail, pfail;
  logic [STAT_W-1:0] live, rst_val;

  pes_op_tracker u_trk (
    .clk, .rst_n,
    .start_req_i, .start_erase_i,
    .fail_any_i (efail | pfail),
    .cmd_suspend_i, .cmd_resume_i, .cmd_abort_i,
    .eng_done_i, .eng_fail_i, .eng_susp_ack_i,
    .ready_o    (ready),
    .susp_o     (susp),
    .susp_req_o (susp_req_o),
    .active_o   (active),
    .set_efail_o(set_ef),
    .set_pfail_o(set_pf)
  );

  pes_fail_bits u_fail (
    .clk, .rst_n,
    .set_efail_i(set_ef),
    .set_pfail_i(set_pf),
    .clear_i    (cmd_clear_i),
    .efail_o    (efail),
    .pfail_o    (pfail)
  );

  always_comb begin
    live          = '0;
    live[BIT_RDY] = ready;
    live[BIT_SUS] = susp;
    live[BIT_EF]  = efail;
    live[BIT_PF]  = pfail;
    live[BIT_PRT] = prot_any_i;
    rst_val          = '0;
    rst_val[BIT_RDY] = 1'b1;
    rst_val[BIT_PRT] = prot_any_i;
  end

  assign start_inhibit_o = active | efail | pfail;

  pes_snap #(.STAT_W(STAT_W), .OUT_W(OUT_W)) u_snap (
    .clk, .rst_n,
    .cap_i    (rd_start_i),
    .live_i   (live),
    .rst_val_i(rst_val),
    .data_o   (rd_data_o)
  );

  // R9: resume drops the suspend request
  p_resume_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_req_o && cmd_resume_i) |=> !susp_req_o);
  // R10: abort from the parked state returns to ready
  p_abort_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_req_o && ready && cmd_abort_i && !cmd_resume_i) |=> (ready && !susp_req_o));
endmodule

// File: tb/pgm_status_ctrl_tb.sv
module pgm_status_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req_i = 0, start_erase_i = 0, cmd_clear_i = 0, cmd_suspend_i = 0;
  logic cmd_resume_i = 0, cmd_abort_i = 0, eng_done_i = 0, eng_fail_i = 0;
  logic eng_susp_ack_i = 0, prot_any_i = 1, rd_start_i = 0;
  logic susp_req_o, start_inhibit_o;
  logic [15:0] rd_data_o;

  int n_run = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pgm_status_ctrl u_dut (.*);

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_in();
    start_req_i = 0; cmd_clear_i = 0; cmd_suspend_i = 0; cmd_resume_i = 0;
    cmd_abort_i = 0; eng_done_i = 0; eng_fail_i = 0; eng_susp_ack_i = 0;
    rd_start_i = 0;
  endtask

  // driver: one read access, expected value goes to the scoreboard
  task automatic rd(input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_start_i = 1;
    tick();
    rd_start_i = 0;
    tick();
  endtask

  task automatic start(input logic erase);
    start_req_i = 1; start_erase_i = erase; tick(); clear_in();
  endtask
  task automatic done(input logic fail);
    eng_done_i = 1; eng_fail_i = fail; tick(); clear_in();
  endtask

  // monitor: compare each captured read with the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      if (rd_start_i && rst_n) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R11: unexpected read, got %h expected none", rd_data_o);
        end else begin
          chk(rd_data_o, exp_q.pop_front(), tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    tick();
    chk(rd_data_o, 16'h0088, "R1 reset value");
    chk({15'd0, start_inhibit_o}, 16'd0, "R1 inhibit low");
    chk({15'd0, susp_req_o}, 16'd0, "R1 no suspend request");
    rd(16'h0088, "R2 R12 idle with protect");
    prot_any_i = 0;
    rd(16'h0080, "R2 bit3 follows protect");

    start(0);
    rd(16'h0000, "R3 busy after start");
    chk({15'd0, start_inhibit_o}, 16'd1, "R6 inhibit while busy");
    done(0);
    rd(16'h0080, "R3 ready after done");

    start(0); done(1);
    rd(16'h0090, "R4 program fail");
    chk({15'd0, start_inhibit_o}, 16'd1, "R6 inhibit on fail");
    start(1);
    rd(16'h0090, "R6 start ignored under fail");
    done(0);
    rd(16'h0090, "R4 stray done keeps fail");
    cmd_clear_i = 1; prot_any_i = 1; tick(); clear_in();
    rd(16'h0088, "R5 clear keeps bit3");
    prot_any_i = 0;

    start(1);
    eng_done_i = 1; eng_fail_i = 1; cmd_clear_i = 1; tick(); clear_in();
    rd(16'h00A0, "R5 set wins over clear");
    cmd_clear_i = 1; tick(); clear_in();
    rd(16'h0080, "R5 clear erase fail");

    start(0);
    cmd_suspend_i = 1; tick(); clear_in();
    rd(16'h0000, "R7 suspend ignored in program");
    chk({15'd0, susp_req_o}, 16'd0, "R7 no request in program");
    done(0);
    cmd_resume_i = 1; tick(); clear_in();
    rd(16'h0080, "R9 resume without suspend");

    start(1);
    cmd_suspend_i = 1; tick(); clear_in();
    rd(16'h0040, "R7 suspend pending");
    chk({15'd0, susp_req_o}, 16'd1, "R7 request raised");
    eng_susp_ack_i = 1; tick(); clear_in();
    rd(16'h00C0, "R8 ready after ack");
    chk({15'd0, start_inhibit_o}, 16'd1, "R6 inhibit while suspended");
    cmd_resume_i = 1; tick(); clear_in();
    rd(16'h0000, "R9 resume clears suspend");
    chk({15'd0, susp_req_o}, 16'd0, "R9 request dropped");
    cmd_suspend_i = 1; tick(); clear_in();
    eng_susp_ack_i = 1; tick(); clear_in();
    cmd_abort_i = 1; tick(); clear_in();
    rd(16'h0080, "R10 abort from suspend");

    start(1);
    cmd_abort_i = 1; tick(); clear_in();
    rd(16'h0000, "R10 abort ignored while running");
    done(0);
    rd(16'h0080, "R3 erase done");

    start(0);
    tick();
    chk(rd_data_o, 16'h0080, "R11 value frozen without access");
    rd(16'h0000, "R11 new access sees busy");
    done(0);

    tick();
    chk(exp_q.size(), 16'd0, "scoreboard drained");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule